// File: doc/BRIEF.md
# Dual-Bank Auto-Indexing Operand Fetch

This block is the operand-fetch stage of a DSP datapath. It holds two independent data memories. Each memory stores 256 words, and each word is a 16-bit two's complement value. Every memory has its own file of four 8-bit address pointers.

On each cycle, a command for each bank picks one pointer and uses its present value as the address. It then optionally moves that pointer up or down by one. A loop can therefore walk a buffer with no separate address arithmetic. Both banks can be accessed in the same cycle, so a coefficient and a sample reach the multiplier together.

Pointers can also be loaded and observed directly. The command inputs stand for fields that an instruction decoder would supply.

Top module: `dual_bank_operand_fetch`

## Requirements
- R1: While reset is asserted, every pointer in both banks reads 0, and `rd_valid` and `op_pair_valid` are low.
- R2: A read (`acc_req`=1, `acc_we`=0) uses the selected pointer's value from before any modification as the address. The word at that address appears on that bank's `rd_data` one clock later, and that bank's `rd_valid` is high for exactly that cycle.
- R3: Modify code 2'b01 increments the selected pointer by one after the access. The increment wraps from 255 to 0.
- R4: Modify code 2'b10 decrements the selected pointer by one after the access. The decrement wraps from 0 to 255.
- R5: Modify codes 2'b00 and 2'b11 leave the selected pointer unchanged, so repeated accesses hit the same word.
- R6: A write (`acc_req`=1, `acc_we`=1) stores `acc_wdata` at the pre-modify address and applies the same modify rule. A write does not raise `rd_valid`.
- R7: When `ld_en` is high, the pointer chosen by `ld_sel` takes `ld_val` at the next clock. `ptr_rd_val` always shows the pointer chosen by `ptr_rd_sel`.
- R8: If a direct load and an auto-modify target the same pointer in the same cycle, the loaded value wins. The access still uses the old pointer value as its address.
- R9: The banks are independent, and both can read in the same cycle. `op_pair_valid` is high exactly when every bank's `rd_valid` is high.
- R10: Within a bank, an access or a load changes only the selected pointer. The other three pointers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 2 | Per-bank access request |
| acc_we | input | 2 | Per-bank write select (1 = write, 0 = read) |
| acc_sel | input | 4 | Per-bank pointer select, 2 bits per bank |
| acc_mod | input | 4 | Per-bank modify code, 2 bits per bank |
| acc_wdata | input | 32 | Per-bank write data, 16 bits per bank |
| ld_en | input | 2 | Per-bank direct pointer load enable |
| ld_sel | input | 4 | Per-bank pointer chosen for loading |
| ld_val | input | 16 | Per-bank value to load, 8 bits per bank |
| ptr_rd_sel | input | 4 | Per-bank pointer chosen for observation |
| ptr_rd_val | output | 16 | Per-bank observed pointer value |
| rd_data | output | 32 | Per-bank registered read data |
| rd_valid | output | 2 | Per-bank read-data strobe |
| op_pair_valid | output | 1 | High when all banks deliver read data together |

## Verification
The first pass fills every address of both banks through incrementing pointers, with a distinct arithmetic pattern for each bank. A second pass reads the whole range back through different pointers that are decrementing. Any address skew, bank swap or wrong wrap shows up as a data mismatch at a known address.

Holding codes, direct loads that collide with a modify, and a write through a decrementing pointer are each tried on their own. These cases separate pre-modify from post-modify addressing, and a load that wins from one that loses. A final access on one bank only confirms that the pair strobe and the idle bank's pointers stay put.

// File: rtl/opf_pkg.sv
package opf_pkg;

  // Per-bank pointer modify code
  typedef enum logic [1:0] {
    MOD_HOLD = 2'b00,
    MOD_INC  = 2'b01,
    MOD_DEC  = 2'b10,
    MOD_RSVD = 2'b11
  } ptr_mod_e;

endpackage

// File: rtl/opf_ptr_file.sv
module opf_ptr_file
  import opf_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_PTR = 4,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic [1:0]        acc_mod,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_val,
  output logic [ADDR_W-1:0] acc_addr
);

  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_d;
  logic [NUM_PTR-1:0]             ptr_en;
  logic [ADDR_W-1:0]              stepped;
  logic                           mod_moves;

  // Pre-modify address straight from the register
  assign acc_addr = ptr_q[acc_sel];
  assign rd_val   = ptr_q[rd_sel];

  // One shared step adder per bank
  always_comb begin
    stepped   = acc_addr;
    mod_moves = 1'b0;
    case (acc_mod)
      MOD_INC: begin
        stepped   = acc_addr + ADDR_W'(1);
        mod_moves = 1'b1;
      end
      MOD_DEC: begin
        stepped   = acc_addr - ADDR_W'(1);
        mod_moves = 1'b1;
      end
      default: begin
        stepped   = acc_addr;
        mod_moves = 1'b0;
      end
    endcase
  end

  // Next-state: a direct load outranks an auto-modify
  always_comb begin
    for (int p = 0; p < NUM_PTR; p++) begin
      if (ld_en && (ld_sel == SEL_W'(p))) begin
        ptr_en[p] = 1'b1;
        ptr_d[p]  = ld_val;
      end else if (acc_req && mod_moves && (acc_sel == SEL_W'(p))) begin
        ptr_en[p] = 1'b1;
        ptr_d[p]  = stepped;
      end else begin
        ptr_en[p] = 1'b0;
        ptr_d[p]  = ptr_q[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      for (int p = 0; p < NUM_PTR; p++) begin
        if (ptr_en[p]) ptr_q[p] <= ptr_d[p];
      end
    end
  end

  // R3: increment after use, modulo the pointer width
  p_ptr_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_mod == MOD_INC && !(ld_en && ld_sel == acc_sel))
    |=> ptr_q[$past(acc_sel)] == $past(acc_addr) + ADDR_W'(1));

  // R4: decrement after use, modulo the pointer width
  p_ptr_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_mod == MOD_DEC && !(ld_en && ld_sel == acc_sel))
    |=> ptr_q[$past(acc_sel)] == $past(acc_addr) - ADDR_W'(1));

  // R5: hold and reserved codes leave the pointer alone
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && (acc_mod == MOD_HOLD || acc_mod == MOD_RSVD)
     && !(ld_en && ld_sel == acc_sel))
    |=> ptr_q[$past(acc_sel)] == $past(acc_addr));

  // R8: a direct load always lands, even against a modify
  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> ptr_q[$past(ld_sel)] == $past(ld_val));

  // R10: with no load and no access, nothing moves
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !acc_req) |=> $stable(ptr_q));

endmodule

// File: rtl/opf_ram_bank.sv
module opf_ram_bank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;
  logic              wr_fire;
  logic              rd_fire;

  assign wr_fire = req && we;
  assign rd_fire = req && !we;

  // Storage: no reset on the array
  always_ff @(posedge clk) begin
    if (wr_fire) mem_q[addr] <= wdata;
  end

  // Registered read port with its own enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_fire;
      if (rd_fire) rd_data_q <= mem_q[addr];
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  // R2: a read yields a strobe one cycle later
  p_rd_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid);

  // R6: writes and idle cycles raise no strobe
  p_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rd_valid);

  // R6: a write lands at the address presented with it
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> mem_q[$past(addr)] == $past(wdata));

endmodule

// File: rtl/opf_bank.sv
module opf_bank #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int NUM_PTR = 4,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic [1:0]        acc_mod,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic [SEL_W-1:0]  ptr_rd_sel,
  output logic [ADDR_W-1:0] ptr_rd_val,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [ADDR_W-1:0] acc_addr;

  opf_ptr_file #(
    .ADDR_W  (ADDR_W),
    .NUM_PTR (NUM_PTR)
  ) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_req  (acc_req),
    .acc_sel  (acc_sel),
    .acc_mod  (acc_mod),
    .ld_en    (ld_en),
    .ld_sel   (ld_sel),
    .ld_val   (ld_val),
    .rd_sel   (ptr_rd_sel),
    .rd_val   (ptr_rd_val),
    .acc_addr (acc_addr)
  );

  opf_ram_bank #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (acc_req),
    .we       (acc_we),
    .addr     (acc_addr),
    .wdata    (acc_wdata),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/dual_bank_operand_fetch.sv
module dual_bank_operand_fetch #(
  parameter int NUM_BANKS = 2,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int NUM_PTR   = 4,
  localparam int SEL_W    = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS-1:0]        acc_req,
  input  logic [NUM_BANKS-1:0]        acc_we,
  input  logic [NUM_BANKS*SEL_W-1:0]  acc_sel,
  input  logic [NUM_BANKS*2-1:0]      acc_mod,
  input  logic [NUM_BANKS*DATA_W-1:0] acc_wdata,
  input  logic [NUM_BANKS-1:0]        ld_en,
  input  logic [NUM_BANKS*SEL_W-1:0]  ld_sel,
  input  logic [NUM_BANKS*ADDR_W-1:0] ld_val,
  input  logic [NUM_BANKS*SEL_W-1:0]  ptr_rd_sel,
  output logic [NUM_BANKS*ADDR_W-1:0] ptr_rd_val,
  output logic [NUM_BANKS*DATA_W-1:0] rd_data,
  output logic [NUM_BANKS-1:0]        rd_valid,
  output logic                        op_pair_valid
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    opf_bank #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .NUM_PTR (NUM_PTR)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_req    (acc_req[b]),
      .acc_we     (acc_we[b]),
      .acc_sel    (acc_sel[b*SEL_W +: SEL_W]),
      .acc_mod    (acc_mod[b*2 +: 2]),
      .acc_wdata  (acc_wdata[b*DATA_W +: DATA_W]),
      .ld_en      (ld_en[b]),
      .ld_sel     (ld_sel[b*SEL_W +: SEL_W]),
      .ld_val     (ld_val[b*ADDR_W +: ADDR_W]),
      .ptr_rd_sel (ptr_rd_sel[b*SEL_W +: SEL_W]),
      .ptr_rd_val (ptr_rd_val[b*ADDR_W +: ADDR_W]),
      .rd_data    (rd_data[b*DATA_W +: DATA_W]),
      .rd_valid   (rd_valid[b])
    );
  end

  assign op_pair_valid = &rd_valid;

  // R9: all banks reading together give a paired operand next cycle
  p_pair_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&(acc_req & ~acc_we)) |=> op_pair_valid);

  // R1: strobes stay low while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (rd_valid == '0 && !op_pair_valid));

endmodule

// File: tb/dual_bank_operand_fetch_bench.sv
module dual_bank_operand_fetch_bench;

  localparam int NB = 2;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NB-1:0]    acc_req, acc_we, ld_en;
  logic [NB*SW-1:0] acc_sel, ld_sel, ptr_rd_sel;
  logic [NB*2-1:0]  acc_mod;
  logic [NB*DW-1:0] acc_wdata, rd_data;
  logic [NB*AW-1:0] ld_val, ptr_rd_val;
  logic [NB-1:0]    rd_valid;
  logic             op_pair_valid;

  int n_chk  = 0;
  int n_fail = 0;
  logic [DW-1:0] model [NB][256];

  always #10 clk = ~clk;

  dual_bank_operand_fetch u_dual_bank_operand_fetch (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
    .acc_sel(acc_sel), .acc_mod(acc_mod), .acc_wdata(acc_wdata),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
    .ptr_rd_sel(ptr_rd_sel), .ptr_rd_val(ptr_rd_val),
    .rd_data(rd_data), .rd_valid(rd_valid), .op_pair_valid(op_pair_valid)
  );

  function automatic logic [DW-1:0] pat(int b, int a);
    logic [DW-1:0] base;
    base = 16'(a * 257);
    return base ^ ((b == 0) ? 16'h0F0F : 16'hA55A);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    acc_req = '0; acc_we = '0; acc_sel = '0; acc_mod = '0; acc_wdata = '0;
    ld_en = '0; ld_sel = '0; ld_val = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic access(int b, bit wr, int sel, logic [1:0] md, logic [DW-1:0] wd);
    acc_req[b] = 1'b1;
    acc_we[b]  = wr;
    acc_sel[b*SW +: SW] = SW'(sel);
    acc_mod[b*2 +: 2]   = md;
    acc_wdata[b*DW +: DW] = wd;
  endtask

  task automatic load(int b, int sel, logic [AW-1:0] v);
    ld_en[b] = 1'b1;
    ld_sel[b*SW +: SW] = SW'(sel);
    ld_val[b*AW +: AW] = v;
  endtask

  task automatic ptr_chk(string req, int b, int sel, logic [AW-1:0] exp);
    ptr_rd_sel[b*SW +: SW] = SW'(sel);
    #1;
    check(req, 32'(ptr_rd_val[b*AW +: AW]), 32'(exp));
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle();
    ptr_rd_sel = '0;
    rst_n = 1'b0;
    repeat (3) step();
    // R1: reset state
    check("R1", 32'(rd_valid), 32'd0);
    check("R1", 32'(op_pair_valid), 32'd0);
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 4; s++) ptr_chk("R1", b, s, 8'd0);
    rst_n = 1'b1;
    step();

    // R6/R3: fill both banks through incrementing pointers
    for (int i = 0; i < 256; i++) begin
      idle();
      access(0, 1'b1, 1, 2'b01, pat(0, i));
      access(1, 1'b1, 2, 2'b01, pat(1, i));
      model[0][i] = pat(0, i);
      model[1][i] = pat(1, i);
      step();
      check("R6", 32'(rd_valid), 32'd0);
    end
    idle();
    // R3: 256 increments wrap back to zero
    ptr_chk("R3", 0, 1, 8'd0);
    ptr_chk("R3", 1, 2, 8'd0);
    // R10: untouched pointers stay zero
    ptr_chk("R10", 0, 0, 8'd0);
    ptr_chk("R10", 0, 3, 8'd0);
    ptr_chk("R10", 1, 1, 8'd0);

    // R7: direct loads
    load(0, 3, 8'd255);
    load(1, 0, 8'd255);
    step();
    idle();
    ptr_chk("R7", 0, 3, 8'd255);
    ptr_chk("R7", 1, 0, 8'd255);
    ptr_chk("R10", 0, 0, 8'd0);

    // R2/R4/R9: read back descending through other pointers
    for (int i = 0; i < 256; i++) begin
      idle();
      access(0, 1'b0, 3, 2'b10, '0);
      access(1, 1'b0, 0, 2'b10, '0);
      step();
      check("R2", 32'(rd_valid), 32'd3);
      check("R9", 32'(op_pair_valid), 32'd1);
      check("R2", 32'(rd_data[0 +: DW]), 32'(model[0][255-i]));
      check("R2", 32'(rd_data[DW +: DW]), 32'(model[1][255-i]));
    end
    idle();
    // R4: decrement past zero wraps to 255
    ptr_chk("R4", 0, 3, 8'd255);
    ptr_chk("R4", 1, 0, 8'd255);
    step();
    check("R2", 32'(rd_valid), 32'd0);

    // R5: hold and reserved codes
    load(0, 1, 8'd7);
    step();
    idle();
    access(0, 1'b0, 1, 2'b00, '0);
    step();
    idle();
    check("R5", 32'(rd_data[0 +: DW]), 32'(model[0][7]));
    ptr_chk("R5", 0, 1, 8'd7);
    access(0, 1'b0, 1, 2'b11, '0);
    step();
    idle();
    check("R5", 32'(rd_data[0 +: DW]), 32'(model[0][7]));
    ptr_chk("R5", 0, 1, 8'd7);

    // R8: load beats a same-cycle modify; access uses old value
    access(0, 1'b0, 1, 2'b01, '0);
    load(0, 1, 8'd50);
    access(1, 1'b0, 0, 2'b10, '0);
    load(1, 0, 8'd9);
    step();
    idle();
    check("R8", 32'(rd_data[0 +: DW]), 32'(model[0][7]));
    check("R8", 32'(rd_data[DW +: DW]), 32'(model[1][255]));
    ptr_chk("R8", 0, 1, 8'd50);
    ptr_chk("R8", 1, 0, 8'd9);

    // R6: write through a decrementing pointer
    load(0, 2, 8'd5);
    step();
    idle();
    access(0, 1'b1, 2, 2'b10, 16'hBEEF);
    model[0][5] = 16'hBEEF;
    step();
    idle();
    check("R6", 32'(rd_valid), 32'd0);
    ptr_chk("R6", 0, 2, 8'd4);
    access(0, 1'b0, 2, 2'b01, '0);
    step();
    idle();
    check("R6", 32'(rd_data[0 +: DW]), 32'(model[0][4]));
    access(0, 1'b0, 2, 2'b00, '0);
    step();
    idle();
    check("R6", 32'(rd_data[0 +: DW]), 32'hBEEF);

    // R9/R10: one bank only; the other keeps its pointers
    access(1, 1'b0, 0, 2'b01, '0);
    step();
    idle();
    check("R9", 32'(rd_valid), 32'd2);
    check("R9", 32'(op_pair_valid), 32'd0);
    check("R9", 32'(rd_data[DW +: DW]), 32'(model[1][9]));
    ptr_chk("R10", 0, 1, 8'd50);
    ptr_chk("R10", 0, 2, 8'd5);
    ptr_chk("R10", 0, 3, 8'd255);
    ptr_chk("R3", 1, 0, 8'd10);
    ptr_chk("R10", 1, 2, 8'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule